// File: doc/BRIEF.md
# Line Overhead Defect Monitor

This block sits after the frame aligner of a SONET/SDH receiver. It sees the line overhead of each received frame once, as three bytes presented with a single-cycle frame strobe: the first protection byte (K1), the second protection byte (K2) and the far-end block error byte taken from the third Z2 position. From these it decides two line-level defects, alarm indication and remote defect indication. Each defect is filtered by a run of consecutive frames whose length depends on a SONET/SDH mode input.

It also keeps a copy of the protection-switching byte pair that only changes after a new pair has repeated for three frames. It adds the far-end block error weights of each frame into a 20-bit saturating counter. A read-and-clear strobe takes a snapshot of that counter and restarts it, and loses no error that arrives in the same cycle.

Top module: `line_oh_monitor`

## Requirements
- R1: After a synchronous active-low reset, both defect outputs are 0, the held protection pair is 0x00/0x00, and the error count and its snapshot are 0.
- R2: With sdh_mode = 0, line alarm indication is set after 5 consecutive strobed frames with K2[2:0] = 3'b111, and cleared after 5 consecutive strobed frames with any other K2[2:0] value. K2[7] is K2 bit 1 and K2[2:0] are bits 6 to 8.
- R3: With sdh_mode = 1, line alarm indication uses a run of 3 frames for both setting and clearing.
- R4: With sdh_mode = 0, line remote defect is set after 5 consecutive strobed frames with K2[2:0] = 3'b110, and cleared after 5 consecutive strobed frames with any other K2[2:0] value.
- R5: With sdh_mode = 1, line remote defect uses a run of 3 frames for both setting and clearing.
- R6: A frame that agrees with the current defect state restarts that defect's run. Cycles without frame_stb change no defect output, whatever the K2 input holds.
- R7: The held pair {aps_k1, aps_k2} takes a new {K1, K2} value only after that same value has arrived in 3 consecutive strobed frames. A run that is broken by a different value must start again from its beginning.
- R8: On each strobed frame the count grows by the value of the Z2 byte when it is 0 to 24. A Z2 value above 24 adds nothing.
- R9: The count saturates at 20'hFFFFF and never wraps.
- R10: When rd_clr is high, the snapshot output takes the count held before that cycle. The count restarts at that cycle's own increment: 0 without a frame strobe, and the clamped Z2 weight with one. Outputs update at the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking valid overhead bytes |
| sdh_mode | input | 1 | 0 = SONET runs of 5 frames, 1 = SDH runs of 3 frames |
| k1_byte | input | 8 | First protection byte of the frame |
| k2_byte | input | 8 | Second protection byte; [2:0] carry the defect code |
| z2_byte | input | 8 | Far-end block error byte (third Z2) |
| rd_clr | input | 1 | Read-and-clear strobe for the error count |
| line_ais | output | 1 | Line alarm indication defect |
| line_rdi | output | 1 | Line remote defect indication |
| aps_k1 | output | 8 | Held protection byte 1 |
| aps_k2 | output | 8 | Held protection byte 2 |
| febe_count | output | 20 | Running far-end block error count |
| febe_snap | output | 20 | Count captured by the last read-and-clear |

## Verification
The defect filters are driven with runs that stop one frame short of the threshold and then reach it. This separates an exact run length from one that is off by one, in both modes. A run broken by a single other code shows that the count restarts and does not carry on. A long run of the remote code while alarm indication is set shows how the two filters hand over in the same frame. The protection capture is given a candidate, an interruption and a return to the candidate, which tells a true three-in-a-row rule from a count of matches. Z2 values of 24, 25 and 255, a long burst to saturation, and read-and-clear with and without a same-cycle frame test the clamp, the ceiling and the handling of the increment that arrives during a clear.

// File: rtl/lom_pkg.sv
// Package: shared types and helpers for the line overhead defect monitor.
// Assumes: overhead bytes are 8 bits wide; the error weight rule is a clamp.
package lom_pkg;

    typedef logic [7:0] oh_byte_t;

    // Three-bit codes carried in the low bits of the second protection byte.
    localparam logic [2:0] CODE_AIS = 3'b111;
    localparam logic [2:0] CODE_RDI = 3'b110;

    // Error weight of one frame: the byte value when within range, else zero.
    function automatic oh_byte_t febe_weight(input oh_byte_t raw, input int unsigned max_w);
        if (int'(raw) <= int'(max_w)) return raw;
        return '0;
    endfunction

endpackage

// File: rtl/persist_filter.sv
// Module: persist_filter
// Keeps one defect flag that flips only after a run of consecutive strobed
// frames disagreeing with it. The run length is picked per frame by the mode
// input. A frame that agrees with the flag restarts the run.
// Assumes: both run lengths are at least 1; stb_i is high for one cycle per frame.
module persist_filter #(
    parameter int SONET_N = 5,
    parameter int SDH_N   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic sdh_i,
    input  logic match_i,
    output logic defect_o
);

    localparam int MAXN = (SONET_N > SDH_N) ? SONET_N : SDH_N;
    localparam int CW   = $clog2(MAXN + 1);
    localparam logic [CW:0] THR_SONET = (CW+1)'(SONET_N);
    localparam logic [CW:0] THR_SDH   = (CW+1)'(SDH_N);

    logic [CW-1:0] run_cnt;
    logic [CW:0]   run_next;
    logic [CW:0]   thr;

    // Pick the run length and form the would-be next run count.
    always_comb begin
        thr      = sdh_i ? THR_SDH : THR_SONET;
        run_next = {1'b0, run_cnt} + 1'b1;
    end

    // Count disagreeing frames and flip the flag when the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            defect_o <= 1'b0;
        end else if (stb_i) begin
            if (match_i == defect_o) begin
                run_cnt <= '0;
            end else if (run_next >= thr) begin
                defect_o <= ~defect_o;
                run_cnt  <= '0;
            end else begin
                run_cnt <= run_next[CW-1:0];
            end
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(defect_o));
    // R6
    agree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && (match_i == defect_o)) |=> $stable(defect_o) && (run_cnt == '0));
    // R2
    run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_cnt) < MAXN);

endmodule

// File: rtl/aps_capture.sv
// Module: aps_capture
// Holds a protection byte pair that changes only after a new value has
// arrived in N consecutive strobed frames. A different value restarts the run.
// Assumes: N >= 2; the value is sampled only on stb_i.
module aps_capture #(
    parameter int W = 16,
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] held_o
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW:0] THR = (CW+1)'(N);

    logic [W-1:0]  cand;
    logic [CW-1:0] cand_cnt;
    logic [CW:0]   cand_next;

    // Next run length if the candidate repeats again.
    always_comb cand_next = {1'b0, cand_cnt} + 1'b1;

    // Track the candidate run and update the held pair once the run is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o   <= '0;
            cand     <= '0;
            cand_cnt <= '0;
        end else if (stb_i) begin
            if (val_i == held_o) begin
                cand_cnt <= '0;
            end else if (val_i == cand) begin
                if (cand_next >= THR) begin
                    held_o   <= val_i;
                    cand_cnt <= '0;
                end else begin
                    cand_cnt <= cand_next[CW-1:0];
                end
            end else begin
                cand     <= val_i;
                cand_cnt <= CW'(1);
            end
        end
    end

    // R7
    aps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(held_o));
    // R7
    aps_new_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && (val_i != cand)) |=> $stable(held_o));
    // R7
    aps_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cand_cnt) < N);

endmodule

// File: rtl/febe_accum.sv
// Module: febe_accum
// Adds clamped per-frame error weights into a saturating counter. A
// read-and-clear strobe copies the count to a snapshot and restarts the count
// at the increment of the same cycle.
// Assumes: at most one frame per cycle; rd_clr_i is a single-cycle request.
module febe_accum #(
    parameter int CW    = 20,
    parameter int MAX_W = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_i,
    input  logic [7:0]    z2_i,
    input  logic          clr_i,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] snap_o
);

    import lom_pkg::*;

    localparam logic [CW:0] CEIL = {1'b0, {CW{1'b1}}};

    logic [CW-1:0] inc;
    logic [CW:0]   sum;
    logic [CW-1:0] sat_sum;

    // Weight of this cycle's frame and the saturated running sum.
    always_comb begin
        inc     = stb_i ? CW'(febe_weight(z2_i, MAX_W)) : '0;
        sum     = {1'b0, count_o} + {1'b0, inc};
        sat_sum = (sum > CEIL) ? CEIL[CW-1:0] : sum[CW-1:0];
    end

    // Accumulate, or snapshot and restart with this cycle's increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            snap_o  <= '0;
        end else if (clr_i) begin
            snap_o  <= count_o;
            count_o <= inc;
        end else begin
            count_o <= sat_sum;
        end
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> count_o >= $past(count_o));
    // R10
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> snap_o == $past(count_o));
    // R10
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !stb_i) |=> count_o == '0);
    // R8
    big_z2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !clr_i && (int'(z2_i) > MAX_W)) |=> $stable(count_o));

endmodule

// File: rtl/line_oh_monitor.sv
// Module: line_oh_monitor (top)
// Per-frame line overhead monitor. Two persistence filters decide the alarm
// and remote defects from K2[2:0], a capture stage holds the protection pair,
// and an accumulator counts far-end block errors.
// Assumes: overhead bytes are valid only while frame_stb is high.
module line_oh_monitor #(
    parameter int SONET_RUN = 5,
    parameter int SDH_RUN   = 3,
    parameter int APS_RUN   = 3,
    parameter int CNT_W     = 20,
    parameter int FEBE_MAX  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             sdh_mode,
    input  logic [7:0]       k1_byte,
    input  logic [7:0]       k2_byte,
    input  logic [7:0]       z2_byte,
    input  logic             rd_clr,
    output logic             line_ais,
    output logic             line_rdi,
    output logic [7:0]       aps_k1,
    output logic [7:0]       aps_k2,
    output logic [CNT_W-1:0] febe_count,
    output logic [CNT_W-1:0] febe_snap
);

    import lom_pkg::*;

    localparam int NDEF = 2;
    localparam logic [2:0] CODES [NDEF] = '{CODE_AIS, CODE_RDI};

    logic [NDEF-1:0] code_hit;
    logic [NDEF-1:0] defect;
    logic [15:0]     aps_pair;

    // One persistence filter per defect code.
    generate
        for (genvar g = 0; g < NDEF; g++) begin : g_def
            assign code_hit[g] = (k2_byte[2:0] == CODES[g]);
            persist_filter #(
                .SONET_N (SONET_RUN),
                .SDH_N   (SDH_RUN)
            ) filt_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .stb_i    (frame_stb),
                .sdh_i    (sdh_mode),
                .match_i  (code_hit[g]),
                .defect_o (defect[g])
            );
        end
    endgenerate

    assign line_ais = defect[0];
    assign line_rdi = defect[1];

    aps_capture #(
        .W (16),
        .N (APS_RUN)
    ) aps_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (frame_stb),
        .val_i  ({k1_byte, k2_byte}),
        .held_o (aps_pair)
    );

    assign aps_k1 = aps_pair[15:8];
    assign aps_k2 = aps_pair[7:0];

    febe_accum #(
        .CW    (CNT_W),
        .MAX_W (FEBE_MAX)
    ) febe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (frame_stb),
        .z2_i    (z2_byte),
        .clr_i   (rd_clr),
        .count_o (febe_count),
        .snap_o  (febe_snap)
    );

    // R2 R4: the two codes exclude each other, so both defects never stand together
    defect_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_ais && line_rdi));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> !line_ais && !line_rdi && (febe_count == '0) && (aps_pair == '0));

endmodule

// File: tb/line_oh_monitor_tb.sv
// Bench: table-driven defect checks, then directed reset, capture and counter tests.
module line_oh_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic        sdh_mode = 1'b0;
    logic [7:0]  k1_byte = '0;
    logic [7:0]  k2_byte = '0;
    logic [7:0]  z2_byte = '0;
    logic        rd_clr = 1'b0;
    logic        line_ais, line_rdi;
    logic [7:0]  aps_k1, aps_k2;
    logic [19:0] febe_count, febe_snap;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    line_oh_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sdh_mode(sdh_mode),
        .k1_byte(k1_byte), .k2_byte(k2_byte), .z2_byte(z2_byte), .rd_clr(rd_clr),
        .line_ais(line_ais), .line_rdi(line_rdi), .aps_k1(aps_k1), .aps_k2(aps_k2),
        .febe_count(febe_count), .febe_snap(febe_snap)
    );

    // Vector: {frames[3:0], sdh, k2 code[2:0], expected ais, expected rdi}
    localparam int NV = 19;
    localparam logic [9:0] VEC [NV] = '{
        {4'd4, 1'b0, 3'b111, 1'b0, 1'b0},
        {4'd1, 1'b0, 3'b111, 1'b1, 1'b0},
        {4'd4, 1'b0, 3'b000, 1'b1, 1'b0},
        {4'd1, 1'b0, 3'b000, 1'b0, 1'b0},
        {4'd4, 1'b0, 3'b110, 1'b0, 1'b0},
        {4'd1, 1'b0, 3'b110, 1'b0, 1'b1},
        {4'd4, 1'b0, 3'b010, 1'b0, 1'b1},
        {4'd1, 1'b0, 3'b010, 1'b0, 1'b0},
        {4'd3, 1'b0, 3'b111, 1'b0, 1'b0},
        {4'd1, 1'b0, 3'b000, 1'b0, 1'b0},
        {4'd4, 1'b0, 3'b111, 1'b0, 1'b0},
        {4'd1, 1'b0, 3'b111, 1'b1, 1'b0},
        {4'd2, 1'b1, 3'b110, 1'b1, 1'b0},
        {4'd1, 1'b1, 3'b110, 1'b0, 1'b1},
        {4'd2, 1'b1, 3'b101, 1'b0, 1'b1},
        {4'd1, 1'b1, 3'b101, 1'b0, 1'b0},
        {4'd2, 1'b1, 3'b111, 1'b0, 1'b0},
        {4'd1, 1'b1, 3'b111, 1'b1, 1'b0},
        {4'd3, 1'b1, 3'b000, 1'b0, 1'b0}
    };

    task automatic check(input string what, input logic [19:0] act, input logic [19:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // One strobed frame driven at a falling edge; outputs are settled at the next one.
    task automatic frame(input logic [7:0] k1, input logic [7:0] k2,
                         input logic [7:0] z2, input logic clr);
        k1_byte = k1; k2_byte = k2; z2_byte = z2;
        frame_stb = 1'b1; rd_clr = clr;
        @(negedge clk);
        frame_stb = 1'b0; rd_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 ais", {19'd0, line_ais}, 20'd0);
        check("R1 rdi", {19'd0, line_rdi}, 20'd0);
        check("R1 aps", {4'd0, aps_k1, aps_k2}, 20'd0);
        check("R1 count", febe_count, 20'd0);
        check("R1 snap", febe_snap, 20'd0);

        // R6: K2 code present without strobe changes nothing
        k2_byte = 8'h07;
        repeat (10) @(negedge clk);
        check("R6 no strobe ais", {19'd0, line_ais}, 20'd0);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            sdh_mode = VEC[v][5];
            for (int f = 0; f < int'(VEC[v][9:6]); f++)
                frame(8'h00, {5'b0, VEC[v][4:2]}, 8'h00, 1'b0);
            check($sformatf("R2-5 vec %0d ais", v), {19'd0, line_ais}, {19'd0, VEC[v][1]});
            check($sformatf("R2-5 vec %0d rdi", v), {19'd0, line_rdi}, {19'd0, VEC[v][0]});
        end

        // R7: protection pair capture
        sdh_mode = 1'b0;
        do_reset();
        frame(8'h5A, 8'h33, 8'hFF, 1'b0);
        frame(8'h5A, 8'h33, 8'hFF, 1'b0);
        check("R7 two frames", {4'd0, aps_k1, aps_k2}, 20'h0);
        frame(8'h5A, 8'h33, 8'hFF, 1'b0);
        check("R7 third frame", {4'd0, aps_k1, aps_k2}, 20'h05A33);
        frame(8'hC1, 8'h20, 8'hFF, 1'b0);
        frame(8'hC1, 8'h20, 8'hFF, 1'b0);
        frame(8'hD2, 8'h20, 8'hFF, 1'b0);
        frame(8'hC1, 8'h20, 8'hFF, 1'b0);
        frame(8'hC1, 8'h20, 8'hFF, 1'b0);
        check("R7 broken run", {4'd0, aps_k1, aps_k2}, 20'h05A33);
        frame(8'hC1, 8'h20, 8'hFF, 1'b0);
        check("R7 rerun done", {4'd0, aps_k1, aps_k2}, 20'h0C120);
        check("R8 z2 255 ignored", febe_count, 20'd0);

        // R8: clamp of the weight
        frame(8'hC1, 8'h20, 8'd24, 1'b0);
        check("R8 z2 24", febe_count, 20'd24);
        frame(8'hC1, 8'h20, 8'd25, 1'b0);
        check("R8 z2 25", febe_count, 20'd24);
        frame(8'hC1, 8'h20, 8'd7, 1'b0);
        check("R8 z2 7", febe_count, 20'd31);

        // R10: read-and-clear with and without a same-cycle frame
        frame(8'hC1, 8'h20, 8'd3, 1'b1);
        check("R10 snap", febe_snap, 20'd31);
        check("R10 count keeps inc", febe_count, 20'd3);
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        check("R10 snap idle", febe_snap, 20'd3);
        check("R10 count idle", febe_count, 20'd0);

        // R9: saturation under a long burst
        z2_byte = 8'd24; frame_stb = 1'b1;
        repeat (43700) @(negedge clk);
        frame_stb = 1'b0;
        check("R9 saturated", febe_count, 20'hFFFFF);
        frame(8'hC1, 8'h20, 8'd24, 1'b0);
        check("R9 holds", febe_count, 20'hFFFFF);
        frame(8'hC1, 8'h20, 8'd5, 1'b1);
        check("R10 snap at ceiling", febe_snap, 20'hFFFFF);
        check("R10 restart", febe_count, 20'd5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule